// File: doc/BRIEF.md
# MII Receive Frame Front-End

This block sits directly behind the receive half of a Media Independent Interface. It samples the nibble, data-valid and error lines on the rising edge of the receive clock. Each cycle is classified by its data-valid, error and nibble code. The block discards the preamble, locks onto the start frame delimiter, and joins the nibbles that follow into bytes. The first nibble of each pair becomes the low half of the byte.

Bytes leave on a plain byte stream that carries valid, start-of-frame, end-of-frame and a frame error flag. A false-carrier code and a burst of activity that never delivers data each raise a one-cycle status pulse. Neither one emits any bytes. Carrier sense and collision are asynchronous to the receive clock. Each is passed through a flop chain into that domain, and both are held low while the link is configured for full duplex.

Top module: `mii_rx_front`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, out_valid, out_sof, out_eof, out_err, false_carrier, runt, crs_sync and col_sync are all 0.
- R2: Nibbles received with rx_dv high before the delimiter produce no output. The delimiter is nibble 4'hD received right after 4'h5, or 4'hD as the very first nibble of an rx_dv burst. A 4'hD after any other nibble is treated as preamble.
- R3: After the delimiter, each pair of nibbles becomes one byte, {second nibble, first nibble}. rxd[0] is the least significant bit.
- R4: The first byte of a frame carries out_sof and the last carries out_eof. The last byte appears in the cycle after the first clock edge that samples rx_dv low. Bytes leave in arrival order, and no byte follows out_eof in the next cycle.
- R5: If rx_er was high together with rx_dv in any cycle of the burst, preamble included, out_err is set on the end-of-frame byte. out_err is never set without out_eof.
- R6: If rx_dv falls after an odd number of data nibbles, out_err is set with out_eof. The trailing nibble is dropped when a whole byte is pending. If that single nibble is the only data, it is emitted as byte {4'h0, nibble} with out_sof, out_eof and out_err.
- R7: A cycle with rx_dv low, rx_er high and rxd = 4'hE raises false_carrier for one cycle, starting on the next cycle, and starts no frame.
- R8: With rx_dv low, rx_er high and rxd being any code other than 4'hE, nothing is emitted and no status pulse is raised.
- R9: If rx_dv falls before a delimiter, or right after the delimiter with no data nibble, runt pulses for one cycle and no byte is emitted.
- R10: crs_sync and col_sync follow crs_async and col_async after two receive clock edges. They are forced to 0 whenever full_duplex is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock from the PHY |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | Link configured for full duplex; masks carrier and collision |
| rxd | input | 4 | Receive nibble, bit 0 least significant |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error |
| crs_async | input | 1 | Carrier sense, asynchronous |
| col_async | input | 1 | Collision, asynchronous |
| out_data | output | 8 | Assembled byte |
| out_valid | output | 1 | out_data holds a byte this cycle |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_err | output | 1 | Frame ended with a media error or an odd nibble count |
| false_carrier | output | 1 | One-cycle false-carrier pulse |
| runt | output | 1 | One-cycle pulse for a burst ended without data |
| crs_sync | output | 1 | Synchronized carrier sense |
| col_sync | output | 1 | Synchronized collision |

## Verification
The close of a frame and a false-carrier report can land on the same cycle. The clock edge that first sees rx_dv low may also carry rx_er high with nibble 4'hE. The bench provokes this by ending one frame with that code on the falling cycle. It then expects the end-of-frame byte, with its own error state, to appear in the same cycle as the false_carrier pulse, and it expects neither event to suppress or change the other.

// File: rtl/mii_rx_front.sv
module mii_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       full_duplex,
  input  logic [3:0] rxd,
  input  logic       rx_dv,
  input  logic       rx_er,
  input  logic       crs_async,
  input  logic       col_async,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_sof,
  output logic       out_eof,
  output logic       out_err,
  output logic       false_carrier,
  output logic       runt,
  output logic       crs_sync,
  output logic       col_sync
);
  typedef enum logic [1:0] {S_IDLE, S_PRE, S_DATA} st_t;
  localparam int SMSB = SYNC_STAGES - 1;

  st_t        st;
  logic       prev5, half, pend_v, pend_first, err_acc;
  logic [3:0] low_nib;
  logic [7:0] pend;
  logic [SMSB:0] crs_q, col_q;

  wire nib5    = (rxd == 4'h5);
  wire nibd    = (rxd == 4'hD);
  wire sfd_now = rx_dv && nibd && (st == S_IDLE || (st == S_PRE && prev5));
  wire fc_code = !rx_dv && rx_er && (rxd == 4'hE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      prev5 <= 1'b0;
      half <= 1'b0;
      pend_v <= 1'b0;
      pend_first <= 1'b0;
      err_acc <= 1'b0;
      low_nib <= '0;
      pend <= '0;
      out_data <= '0;
      out_valid <= 1'b0;
      out_sof <= 1'b0;
      out_eof <= 1'b0;
      out_err <= 1'b0;
      false_carrier <= 1'b0;
      runt <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_sof <= 1'b0;
      out_eof <= 1'b0;
      out_err <= 1'b0;
      runt <= 1'b0;
      false_carrier <= fc_code;
      if (rx_dv) err_acc <= (st == S_IDLE) ? rx_er : (err_acc | rx_er);
      case (st)
        S_IDLE: if (rx_dv) begin
          st <= sfd_now ? S_DATA : S_PRE;
          prev5 <= nib5;
          half <= 1'b0;
          pend_v <= 1'b0;
        end
        S_PRE: begin
          if (!rx_dv) begin
            st <= S_IDLE;
            runt <= 1'b1;
          end else begin
            if (sfd_now) begin
              st <= S_DATA;
              half <= 1'b0;
              pend_v <= 1'b0;
            end
            prev5 <= nib5;
          end
        end
        S_DATA: begin
          if (rx_dv) begin
            if (!half) begin
              low_nib <= rxd;
              half <= 1'b1;
            end else begin
              half <= 1'b0;
              pend <= {rxd, low_nib};
              pend_v <= 1'b1;
              pend_first <= !pend_v;
              if (pend_v) begin
                out_valid <= 1'b1;
                out_data <= pend;
                out_sof <= pend_first;
              end
            end
          end else begin
            st <= S_IDLE;
            if (pend_v) begin
              out_valid <= 1'b1;
              out_data <= pend;
              out_sof <= pend_first;
              out_eof <= 1'b1;
              out_err <= err_acc | half;
            end else if (half) begin
              out_valid <= 1'b1;
              out_data <= {4'h0, low_nib};
              out_sof <= 1'b1;
              out_eof <= 1'b1;
              out_err <= 1'b1;
            end else begin
              runt <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          crs_q <= '0;
          col_q <= '0;
        end else begin
          crs_q <= {crs_q[SMSB-1:0], crs_async};
          col_q <= {col_q[SMSB-1:0], col_async};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          crs_q <= '0;
          col_q <= '0;
        end else begin
          crs_q <= crs_async;
          col_q <= col_async;
        end
      end
    end
  endgenerate

  assign crs_sync = crs_q[SMSB] & ~full_duplex;
  assign col_sync = col_q[SMSB] & ~full_duplex;
endmodule

// File: rtl/mii_rx_front_chk.sv
module mii_rx_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       full_duplex,
  input logic [3:0] rxd,
  input logic       rx_dv,
  input logic       rx_er,
  input logic       out_valid,
  input logic       out_sof,
  input logic       out_eof,
  input logic       out_err,
  input logic       false_carrier,
  input logic       runt,
  input logic       crs_sync,
  input logic       col_sync
);
  a_r4_sof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  a_r4_eof_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid);
  a_r4_quiet_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |=> !out_valid);
  a_r3_byte_while_dv: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eof) |-> $past(rx_dv));
  a_r5_err_at_eof: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_eof);
  a_r7_fc_from_code: assert property (@(posedge clk) disable iff (!rst_n)
    false_carrier |-> $past(!rx_dv && rx_er && rxd == 4'hE));
  a_r9_runt_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
    runt |-> !out_valid);
  a_r10_fd_mask: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |-> (!crs_sync && !col_sync));
endmodule

bind mii_rx_front mii_rx_front_chk u_chk (.*);

// File: tb/sim_mii_rx_front.sv
module sim_mii_rx_front;
  logic clk = 0, rst_n = 0, full_duplex = 0;
  logic [3:0] rxd = 0;
  logic rx_dv = 0, rx_er = 0, crs_async = 0, col_async = 0;
  logic [7:0] out_data;
  logic out_valid, out_sof, out_eof, out_err, false_carrier, runt, crs_sync, col_sync;

  int vectors = 0, fails = 0, fc_cnt = 0, fc_exp = 0, runt_cnt = 0, runt_exp = 0;
  bit done = 0;
  logic [10:0] expq[$];

  always #5 clk = ~clk;

  mii_rx_front u0 (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (false_carrier) fc_cnt++;
    if (runt) runt_cnt++;
    if (out_valid) begin
      logic [10:0] got, exp;
      got = {out_err, out_eof, out_sof, out_data};
      if (expq.size() == 0) chk(0, "R2/R9 unexpected byte", int'(got), 0);
      else begin
        exp = expq.pop_front();
        chk(got == exp, "R3/R4/R5/R6 byte {err,eof,sof,data}", int'(got), int'(exp));
      end
    end
  end

  task automatic nib(logic [3:0] d, bit e);
    rx_dv = 1; rx_er = e; rxd = d;
    @(negedge clk);
  endtask

  task automatic idle(int n, logic [3:0] d, bit e);
    rx_dv = 0; rx_er = e; rxd = d;
    repeat (n) @(negedge clk);
  endtask

  task automatic settle(string req);
    idle(3, 4'h0, 0);
    chk(expq.size() == 0, {req, " bytes outstanding"}, expq.size(), 0);
    chk(fc_cnt == fc_exp, "R7 false carrier count", fc_cnt, fc_exp);
    chk(runt_cnt == runt_exp, "R9 runt count", runt_cnt, runt_exp);
  endtask

  task automatic frame(int pre_n, bit junk, int nb, logic [7:0] seed, int er_idx, bit odd, bit fc_end, string req);
    int k = 0;
    bit bad = (er_idx >= 0) || odd;
    if (junk) begin
      nib(4'h3, k == er_idx); k++;
      nib(4'hD, k == er_idx); k++;
    end
    repeat (pre_n) begin nib(4'h5, k == er_idx); k++; end
    nib(4'hD, k == er_idx); k++;
    for (int i = 0; i < nb; i++) begin
      logic [7:0] b;
      b = seed + 8'(i * 37);
      expq.push_back({bad && (i == nb - 1), i == nb - 1, i == 0, b});
      nib(b[3:0], k == er_idx); k++;
      nib(b[7:4], k == er_idx); k++;
    end
    if (odd) begin
      if (nb == 0) expq.push_back({3'b111, 8'h0A});
      nib(4'hA, k == er_idx); k++;
    end
    if (nb == 0 && !odd) runt_exp++;
    if (fc_end) fc_exp++;
    idle(1, fc_end ? 4'hE : 4'h0, fc_end);
    settle(req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !out_sof && !out_eof && !out_err && !false_carrier && !runt && !crs_sync && !col_sync,
        "R1 reset outputs", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid && !false_carrier && !runt, "R1 after release", int'(out_valid), 0);

    frame(15, 0, 4, 8'h3C, -1, 0, 0, "R2 R3 R4 long preamble");
    frame(0, 0, 3, 8'hA5, -1, 0, 0, "R2 sfd first nibble");
    frame(4, 1, 2, 8'h71, -1, 0, 0, "R2 stray D in preamble");
    frame(1, 0, 1, 8'hE2, -1, 0, 0, "R4 single byte");
    frame(7, 0, 5, 8'h10, 14, 0, 0, "R5 error mid frame");
    frame(7, 0, 2, 8'h99, 1, 0, 0, "R5 error in preamble");
    frame(3, 0, 2, 8'h5A, -1, 1, 0, "R6 odd trailing nibble");
    frame(3, 0, 0, 8'h00, -1, 1, 0, "R6 lone nibble");
    frame(3, 0, 0, 8'h00, -1, 0, 0, "R9 sfd then fall");
    frame(5, 0, 3, 8'hC3, -1, 0, 1, "R4 R7 eof with false carrier");

    repeat (5) nib(4'h5, 0);
    runt_exp++;
    settle("R9 no delimiter");

    idle(1, 4'hE, 1);
    fc_exp++;
    settle("R7 false carrier alone");

    idle(1, 4'h1, 1); idle(1, 4'h5, 1); idle(1, 4'hF, 1); idle(1, 4'hD, 1); idle(1, 4'h0, 1);
    settle("R8 reserved codes");

    crs_async = 1; col_async = 1;
    @(negedge clk);
    chk(!crs_sync && !col_sync, "R10 one edge", int'(crs_sync), 0);
    @(negedge clk);
    chk(crs_sync && col_sync, "R10 two edges", int'(crs_sync), 1);
    full_duplex = 1;
    #1;
    chk(!crs_sync && !col_sync, "R10 full duplex mask", int'(crs_sync), 0);
    full_duplex = 0; crs_async = 0; col_async = 0;
    repeat (3) @(negedge clk);
    chk(!crs_sync && !col_sync, "R10 release", int'(crs_sync), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule